// File: doc/BRIEF.md
# Indexed Addressing Bus Sequencer

This block produces the bus cycles an 8-bit processor spends on working out an operand's effective address. An instruction decoder pulses `start` with the addressing mode, the access class, the program counter and both index registers. The sequencer then fetches operand bytes from the instruction stream. It reads pointer bytes from page zero and issues the dummy reads the mode calls for. When the last addressing cycle is done, it raises a one-cycle `exec_ready` with the effective address and the advanced program counter.

Three access classes are supported. A read access skips the page-fix cycle when adding the index gives no carry. A write access always takes that cycle. A read-modify-write access also always takes it, then reads the operand at the effective address and writes the unchanged value back before handing off. The execute stage then writes the modified value. The arithmetic of the instruction itself is not part of this block.

Top module: `ixseq_top`

## Requirements
- R1: After a synchronous reset, `bus_rd`, `bus_wr` and `exec_ready` are all low until `start` is seen.
- R2: Mode 0 (page zero) fetches one byte at the program counter; the effective address is that byte with a zero high byte and the program counter advances by one.
- R3: Modes 1 and 2 (page zero plus X, page zero plus Y) fetch a base byte, then do a dummy read at the base address in page zero; the effective address is (base + index) mod 256 in page zero.
- R4: Mode 3 (absolute) fetches the low then the high byte at successive program counter values. The program counter advances by exactly one per byte fetched from the instruction stream and never in any other cycle.
- R5: Modes 4 and 5 (absolute plus X, absolute plus Y) with class 0 or class 3 (both read): no dummy cycle when low + index < 256; otherwise one dummy read at {high, (low + index) mod 256}, followed by an effective address 256 higher (mod 65536).
- R6: With class 1 (write) or class 2 (read-modify-write), modes 4, 5 and 7 always do the dummy read at the partially formed address, carry or not.
- R7: Mode 6 (indexed indirect) fetches a pointer and does a dummy read at it. It adds X mod 256, then reads the low byte at the new pointer and the high byte at (pointer + 1) mod 256, both in page zero.
- R8: Mode 7 (indirect indexed) fetches a pointer, reads the low byte at it and the high byte at (pointer + 1) mod 256 in page zero, then applies Y with the carry rule of R5 and R6.
- R9: For class 2, after the address is formed, one read at the effective address is followed by one write of the same value to the same address. That value is presented on `opnd_o` with `exec_ready`.
- R10: `start` and the request inputs are ignored while a sequence is in progress; mode, class and indices are latched when the sequence begins.
- R11: `exec_ready` lasts exactly one cycle, the cycle after the final bus cycle, and no bus access happens in it. `bus_rd` and `bus_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| mode_i | input | 3 | Addressing mode code 0..7 |
| cls_i | input | 2 | Access class: 0 read, 1 write, 2 read-modify-write, 3 read |
| pc_i | input | 16 | Address of the first operand byte |
| x_i | input | 8 | X index |
| y_i | input | 8 | Y index |
| rd_data | input | 8 | Read data, captured at the end of each read cycle |
| bus_addr | output | 16 | Bus address of the current cycle |
| bus_rd | output | 1 | Read cycle (real or dummy) |
| bus_wr | output | 1 | Write cycle |
| bus_wdata | output | 8 | Write data |
| ea_o | output | 16 | Effective address, valid with exec_ready |
| pc_o | output | 16 | Advanced program counter, valid with exec_ready |
| opnd_o | output | 8 | Operand read during read-modify-write |
| exec_ready | output | 1 | One-cycle hand-off pulse to the execute stage |

## Verification
The request is taken at the clock edge where `start` is high. The first bus cycle appears in the cycle that follows, and each later bus cycle lasts exactly one clock, with read data captured at its closing edge. `exec_ready`, `ea_o`, `pc_o` and `opnd_o` are due one cycle after the last bus cycle, and the sequencer is idle one cycle after that. The bench builds the expected list of cycles for each request from its own memory model. It supplies read data and compares every bus cycle at the falling edge of that same cycle, then checks the hand-off cycle and the idle cycle at the next two falling edges.

// File: rtl/ixseq_pkg.sv
`timescale 1ns/1ps
package ixseq_pkg;

    localparam int unsigned BW = 8;
    localparam int unsigned AW = 2 * BW;

    typedef logic [BW-1:0] byte_t;
    typedef logic [AW-1:0] addr_t;

    typedef enum logic [2:0] {
        MD_ZP   = 3'd0,
        MD_ZPX  = 3'd1,
        MD_ZPY  = 3'd2,
        MD_ABS  = 3'd3,
        MD_ABSX = 3'd4,
        MD_ABSY = 3'd5,
        MD_INDX = 3'd6,
        MD_INDY = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        CL_RD  = 2'd0,
        CL_WR  = 2'd1,
        CL_RMW = 2'd2,
        CL_RD2 = 2'd3
    } cls_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPLO,
        ST_OPHI,
        ST_ZPDUM,
        ST_PTRDUM,
        ST_PTRLO,
        ST_PTRHI,
        ST_FIX,
        ST_RMWRD,
        ST_RMWWB,
        ST_DONE
    } st_e;

    typedef struct packed {
        mode_e mode;
        cls_e  cls;
        byte_t x;
        byte_t y;
    } req_t;

    function automatic logic uses_y(mode_e m);
        return (m == MD_ZPY) || (m == MD_ABSY) || (m == MD_INDY);
    endfunction

    function automatic logic fix_always(cls_e c);
        return (c == CL_WR) || (c == CL_RMW);
    endfunction

    function automatic st_e after_addr(cls_e c);
        return (c == CL_RMW) ? ST_RMWRD : ST_DONE;
    endfunction

endpackage

// File: rtl/ixseq_idx_add.sv
`timescale 1ns/1ps
module ixseq_idx_add #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         co
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b};
        sum  = full[W-1:0];
        co   = full[W];
    end
endmodule

// File: rtl/ixseq_fsm.sv
`timescale 1ns/1ps
module ixseq_fsm
    import ixseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  mode_e mode,
    input  cls_e  cls,
    input  logic  carry,
    output st_e   state
);
    st_e nxt;
    st_e post;
    st_e fix_nxt;

    always_comb begin
        post    = after_addr(cls);
        fix_nxt = (fix_always(cls) || carry) ? ST_FIX : post;
        case (state)
            ST_IDLE:   nxt = start ? ST_OPLO : ST_IDLE;
            ST_OPLO: begin
                case (mode)
                    MD_ZP:                  nxt = post;
                    MD_ZPX, MD_ZPY:         nxt = ST_ZPDUM;
                    MD_ABS, MD_ABSX, MD_ABSY: nxt = ST_OPHI;
                    MD_INDX:                nxt = ST_PTRDUM;
                    default:                nxt = ST_PTRLO;
                endcase
            end
            ST_OPHI:   nxt = (mode == MD_ABS) ? post : fix_nxt;
            ST_ZPDUM:  nxt = post;
            ST_PTRDUM: nxt = ST_PTRLO;
            ST_PTRLO:  nxt = ST_PTRHI;
            ST_PTRHI:  nxt = (mode == MD_INDX) ? post : fix_nxt;
            ST_FIX:    nxt = post;
            ST_RMWRD:  nxt = ST_RMWWB;
            ST_RMWWB:  nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/ixseq_top.sv
`timescale 1ns/1ps
module ixseq_top
    import ixseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    mode_i,
    input  logic [1:0]    cls_i,
    input  logic [AW-1:0] pc_i,
    input  logic [BW-1:0] x_i,
    input  logic [BW-1:0] y_i,
    input  logic [BW-1:0] rd_data,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [BW-1:0] bus_wdata,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] pc_o,
    output logic [BW-1:0] opnd_o,
    output logic          exec_ready
);
    localparam byte_t ZPAGE = '0;

    req_t  req_r;
    addr_t pc_r;
    addr_t ea_r;
    byte_t ptr_r;
    byte_t ptr_nx;
    byte_t opnd_r;
    logic  carry_r;
    st_e   state;

    byte_t idx;
    byte_t add_a;
    byte_t add_b;
    byte_t add_sum;
    logic  add_co;

    // one shared byte adder: pointer + X in the pointer dummy cycle,
    // address low byte + index everywhere else
    always_comb begin
        idx = uses_y(req_r.mode) ? req_r.y : req_r.x;
        if (state == ST_PTRDUM) begin
            add_a = ptr_r;
            add_b = req_r.x;
        end else begin
            add_a = ea_r[BW-1:0];
            add_b = idx;
        end
        ptr_nx = ptr_r + byte_t'(1);
    end

    ixseq_idx_add #(.W(BW)) u_add (
        .a   (add_a),
        .b   (add_b),
        .sum (add_sum),
        .co  (add_co)
    );

    ixseq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .mode  (req_r.mode),
        .cls   (req_r.cls),
        .carry (add_co),
        .state (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_r   <= '0;
            pc_r    <= '0;
            ea_r    <= '0;
            ptr_r   <= '0;
            opnd_r  <= '0;
            carry_r <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_r.mode <= mode_e'(mode_i);
                        req_r.cls  <= cls_e'(cls_i);
                        req_r.x    <= x_i;
                        req_r.y    <= y_i;
                        pc_r       <= pc_i;
                    end
                end
                ST_OPLO: begin
                    ea_r  <= {ZPAGE, rd_data};
                    ptr_r <= rd_data;
                    pc_r  <= pc_r + addr_t'(1);
                end
                ST_OPHI: begin
                    pc_r <= pc_r + addr_t'(1);
                    if (req_r.mode == MD_ABS) begin
                        ea_r[AW-1:BW] <= rd_data;
                    end else begin
                        ea_r    <= {rd_data, add_sum};
                        carry_r <= add_co;
                    end
                end
                ST_ZPDUM:  ea_r[BW-1:0] <= add_sum;
                ST_PTRDUM: ptr_r <= add_sum;
                ST_PTRLO:  ea_r[BW-1:0] <= rd_data;
                ST_PTRHI: begin
                    if (req_r.mode == MD_INDX) begin
                        ea_r[AW-1:BW] <= rd_data;
                    end else begin
                        ea_r    <= {rd_data, add_sum};
                        carry_r <= add_co;
                    end
                end
                ST_FIX:    ea_r[AW-1:BW] <= ea_r[AW-1:BW] + {{(BW-1){1'b0}}, carry_r};
                ST_RMWRD:  opnd_r <= rd_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = ea_r;
        bus_wdata = opnd_r;
        case (state)
            ST_OPLO, ST_OPHI: begin
                bus_rd   = 1'b1;
                bus_addr = pc_r;
            end
            ST_ZPDUM: begin
                bus_rd   = 1'b1;
                bus_addr = {ZPAGE, ea_r[BW-1:0]};
            end
            ST_PTRDUM, ST_PTRLO: begin
                bus_rd   = 1'b1;
                bus_addr = {ZPAGE, ptr_r};
            end
            ST_PTRHI: begin
                bus_rd   = 1'b1;
                bus_addr = {ZPAGE, ptr_nx};
            end
            ST_FIX, ST_RMWRD: bus_rd = 1'b1;
            ST_RMWWB:         bus_wr = 1'b1;
            default: ;
        endcase
    end

    assign ea_o       = ea_r;
    assign pc_o       = pc_r;
    assign opnd_o     = opnd_r;
    assign exec_ready = (state == ST_DONE);

endmodule

// File: rtl/ixseq_chk.sv
`timescale 1ns/1ps
module ixseq_chk
    import ixseq_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input st_e   state,
    input logic  bus_rd,
    input logic  bus_wr,
    input addr_t bus_addr,
    input byte_t bus_wdata,
    input byte_t rd_data,
    input logic  exec_ready,
    input addr_t pc_r,
    input addr_t ea_r,
    input logic  carry_r
);
    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        exec_ready |=> !exec_ready);

    p_rmw_echo_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && state == ST_RMWRD) |=>
            (bus_wr && bus_addr == $past(bus_addr) && bus_wdata == $past(rd_data)));

    p_fix_page_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIX) |=>
            (ea_r == ($past(bus_addr) + ($past(carry_r) ? 16'h0100 : 16'h0000))));

    p_pc_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state != ST_OPLO && state != ST_OPHI && state != ST_IDLE) |=> $stable(pc_r));
endmodule

bind ixseq_top ixseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rd_data    (rd_data),
    .exec_ready (exec_ready),
    .pc_r       (pc_r),
    .ea_r       (ea_r),
    .carry_r    (carry_r)
);

// File: tb/sim_ixseq_top.sv
`timescale 1ns/1ps
module sim_ixseq_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  mode_i;
    logic [1:0]  cls_i;
    logic [15:0] pc_i;
    logic [7:0]  x_i;
    logic [7:0]  y_i;
    logic [7:0]  rd_data;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [15:0] ea_o;
    logic [15:0] pc_o;
    logic [7:0]  opnd_o;
    logic        exec_ready;

    always #2.5 clk = ~clk;

    ixseq_top u0 (
        .clk(clk), .rst(rst), .start(start), .mode_i(mode_i), .cls_i(cls_i),
        .pc_i(pc_i), .x_i(x_i), .y_i(y_i), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .ea_o(ea_o), .pc_o(pc_o), .opnd_o(opnd_o), .exec_ready(exec_ready)
    );

    int n_vec = 0;
    int n_bad = 0;

    int mem [int];

    typedef struct {
        int wr;
        int addr;
        int wd;
    } cyc_t;

    cyc_t exp_q[$];
    int exp_ea;
    int exp_pc;
    int exp_op;

    function automatic int rdv(int a);
        if (mem.exists(a)) return mem[a] & 255;
        return ((a * 37 + 5) ^ (a >> 8)) & 255;
    endfunction

    task automatic chk(string tag, string what, int act, int expv);
        n_vec++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic void push(int wr, int addr, int wd);
        cyc_t c;
        c.wr = wr; c.addr = addr & 16'hFFFF; c.wd = wd;
        exp_q.push_back(c);
    endfunction

    // behavioural reference: list of expected bus cycles for one request
    task automatic build(int md, int cl, int pc, int x, int y);
        int p, lo, hi, b, z, sum, idx;
        bit fix_any;
        exp_q.delete();
        exp_op = 0;
        p = pc;
        idx = (md == 2 || md == 5 || md == 7) ? y : x;
        fix_any = (cl == 1 || cl == 2);
        case (md)
            0: begin
                lo = rdv(p); push(0, p, 0); p = (p + 1) & 16'hFFFF;
                exp_ea = lo;
            end
            1, 2: begin
                b = rdv(p); push(0, p, 0); p = (p + 1) & 16'hFFFF;
                push(0, b, 0);
                exp_ea = (b + idx) & 255;
            end
            3, 4, 5: begin
                lo = rdv(p); push(0, p, 0); p = (p + 1) & 16'hFFFF;
                hi = rdv(p); push(0, p, 0); p = (p + 1) & 16'hFFFF;
                if (md == 3) exp_ea = hi * 256 + lo;
                else begin
                    sum = lo + idx;
                    if (fix_any || sum > 255) push(0, hi * 256 + (sum & 255), 0);
                    exp_ea = (hi * 256 + lo + idx) & 16'hFFFF;
                end
            end
            6: begin
                z = rdv(p); push(0, p, 0); p = (p + 1) & 16'hFFFF;
                push(0, z, 0);
                z = (z + x) & 255;
                lo = rdv(z); push(0, z, 0);
                hi = rdv((z + 1) & 255); push(0, (z + 1) & 255, 0);
                exp_ea = hi * 256 + lo;
            end
            default: begin
                z = rdv(p); push(0, p, 0); p = (p + 1) & 16'hFFFF;
                lo = rdv(z); push(0, z, 0);
                hi = rdv((z + 1) & 255); push(0, (z + 1) & 255, 0);
                sum = lo + y;
                if (fix_any || sum > 255) push(0, hi * 256 + (sum & 255), 0);
                exp_ea = (hi * 256 + lo + y) & 16'hFFFF;
            end
        endcase
        if (cl == 2) begin
            exp_op = rdv(exp_ea);
            push(0, exp_ea, 0);
            push(1, exp_ea, exp_op);
        end
        exp_pc = p;
    endtask

    task automatic run_op(string tag, int md, int cl, int pc, int x, int y, bit hold);
        int act, ex;
        build(md, cl, pc, x, y);
        @(negedge clk);
        start = 1'b1; mode_i = 3'(md); cls_i = 2'(cl);
        pc_i = 16'(pc); x_i = 8'(x); y_i = 8'(y);
        @(posedge clk);
        foreach (exp_q[i]) begin
            @(negedge clk);
            if (hold) begin
                start = 1'b1; mode_i = ~3'(md); cls_i = ~2'(cl);
                pc_i = ~16'(pc); x_i = ~8'(x); y_i = ~8'(y);
            end else begin
                start = 1'b0;
            end
            rd_data = 8'(rdv(int'(bus_addr)));
            act = int'({bus_wr, bus_rd, bus_addr});
            ex  = (exp_q[i].wr << 17) | ((exp_q[i].wr == 0 ? 1 : 0) << 16) | exp_q[i].addr;
            chk(tag, $sformatf("cycle %0d wr/rd/addr", i), act, ex);
            if (exp_q[i].wr != 0) chk(tag, "write data", int'(bus_wdata), exp_q[i].wd);
            chk("R11", "ready early", int'(exec_ready), 0);
        end
        @(negedge clk);
        start = 1'b0;
        chk("R11", "ready pulse", int'(exec_ready), 1);
        chk("R11", "no bus at hand-off", int'({bus_wr, bus_rd}), 0);
        chk(tag, "effective address", int'(ea_o), exp_ea);
        chk(tag, "program counter", int'(pc_o), exp_pc);
        if (cl == 2) chk("R9", "rmw operand", int'(opnd_o), exp_op);
        @(negedge clk);
        chk("R11", "ready single", int'(exec_ready), 0);
        chk(tag, "idle after", int'({bus_wr, bus_rd}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; mode_i = '0; cls_i = '0;
        pc_i = '0; x_i = '0; y_i = '0; rd_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "reset read", int'(bus_rd), 0);
        chk("R1", "reset write", int'(bus_wr), 0);
        chk("R1", "reset ready", int'(exec_ready), 0);
        @(negedge clk);
        chk("R1", "idle no start", int'({bus_wr, bus_rd, exec_ready}), 0);

        // R2 page zero
        mem[16'h1234] = 8'h56;
        run_op("R2", 0, 0, 16'h1234, 8'h11, 8'h22, 0);

        // R3 page-zero indexed with wrap
        mem[16'h2000] = 8'hF0;
        run_op("R3", 1, 0, 16'h2000, 8'h20, 8'h01, 0);
        mem[16'h2100] = 8'h80;
        run_op("R3", 2, 1, 16'h2100, 8'hFF, 8'h05, 0);

        // R4 absolute
        mem[16'h3000] = 8'h34; mem[16'h3001] = 8'h12;
        run_op("R4", 3, 0, 16'h3000, 8'h00, 8'h00, 0);
        run_op("R4", 3, 0, 16'hFFFF, 8'h00, 8'h00, 0);

        // R5 read class: no carry, carry, class 3 with address wrap
        mem[16'h3100] = 8'h10; mem[16'h3101] = 8'h40;
        run_op("R5", 4, 0, 16'h3100, 8'h05, 8'h00, 0);
        mem[16'h3200] = 8'hF0; mem[16'h3201] = 8'h40;
        run_op("R5", 4, 0, 16'h3200, 8'h20, 8'h00, 0);
        mem[16'h3300] = 8'hFF; mem[16'h3301] = 8'hFF;
        run_op("R5", 5, 3, 16'h3300, 8'h00, 8'h01, 0);

        // R6 write class always takes the dummy cycle
        run_op("R6", 4, 1, 16'h3100, 8'h05, 8'h00, 0);
        mem[16'h6000] = 8'h40; mem[16'h0040] = 8'h10; mem[16'h0041] = 8'h22;
        run_op("R6", 7, 1, 16'h6000, 8'h00, 8'h03, 0);

        // R9 read-modify-write
        run_op("R9", 3, 2, 16'h3000, 8'h00, 8'h00, 0);
        run_op("R9", 5, 2, 16'h3200, 8'h00, 8'h20, 0);
        mem[16'h6100] = 8'h33;
        run_op("R9", 0, 2, 16'h6100, 8'h00, 8'h00, 0);

        // R7 indexed indirect with pointer wrap
        mem[16'h5000] = 8'hFE; mem[16'h00FF] = 8'h34; mem[16'h0000] = 8'h12;
        run_op("R7", 6, 0, 16'h5000, 8'h01, 8'h00, 0);

        // R8 indirect indexed: pointer at top of page zero, then carry case
        mem[16'h5100] = 8'hFF; mem[16'h00FF] = 8'h80; mem[16'h0000] = 8'h22;
        run_op("R8", 7, 0, 16'h5100, 8'h00, 8'h10, 0);
        mem[16'h5200] = 8'h40; mem[16'h0040] = 8'hF0; mem[16'h0041] = 8'h22;
        run_op("R8", 7, 0, 16'h5200, 8'h00, 8'h20, 0);

        // R10 start and request inputs ignored while busy
        run_op("R10", 1, 0, 16'h2000, 8'h20, 8'h01, 1);
        run_op("R10", 6, 2, 16'h5000, 8'h01, 8'h00, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule